// File: doc/BRIEF.md
# Fetch Thread Status Controller

This block tracks the fetch status of every hardware thread in a multithreaded instruction fetch front end. Each cycle it gathers the control traffic that arrives at fetch from later pipeline stages: stall and release pulses from four downstream stages (decode, rename, execute, commit), redirect requests from commit and decode with their target addresses, a level that says the reorder buffer is still flushing, and instruction-cache responses tagged with a request number. From these it computes, for each thread, the next fetch status, the redirected fetch address pair, and the tag of its outstanding cache request. It also keeps one flag telling whether the stage as a whole has work.

The fetch datapath tells the block when it launches a cache request for a thread (`fetch_req_i`) and when a thread whose line has arrived gets its fetch slot (`fetch_slot_i`). Repair of the branch predictor and removal of younger instructions are done elsewhere; the block only emits one-cycle flush pulses that start them. Every output is registered: inputs sampled at a rising edge show their effect on the outputs right after that edge.

Cache responses arrive on a valid/ready stream. The block never applies back-pressure: `resp_ready_o` is always high, so a response is consumed in the cycle its valid is high, whether it is accepted or dropped.

Top module: `fetch_thread_status`

## Requirements
- R1: During and right after reset every thread is Running (code 0), its PC equals RESET_PC and its next PC equals RESET_PC+4, its request tag is 0; the stage-active flag, the notify pulse, the dropped-response count, the flush pulses and the error flag are all 0.
- R2: Each thread has one sticky stall flag per downstream stage (bit index thread*4+stage; stage 0 decode, 1 rename, 2 execute, 3 commit), set by its block pulse and cleared by its unblock pulse; a thread is stalled when any of its four flags (after this cycle's pulses) is set or the global context-switch level is high.
- R3: A commit squash has top priority: the thread becomes Squashing (code 2), its PC becomes the commit target and its next PC the target plus 4, and `commit_flush_o` for that thread pulses for one cycle.
- R4: Without a commit squash, a high reorder-buffer-flushing level puts or holds the thread in Squashing without changing its PC.
- R5: Otherwise a decode squash redirects (PC = decode target, next PC = target + 4), sets Squashing and pulses `decode_flush_o`, unless the thread is already Squashing, in which case the PC stays unchanged and no pulse is raised.
- R6: Otherwise a stalled thread goes to Blocked (code 3), except a thread in WaitResponse (code 4), which is left waiting.
- R7: Otherwise a thread in Blocked or Squashing returns to Running.
- R8: A fetch request for a thread in Running, with no higher-priority event, moves it to WaitResponse and increments its tag (modulo 2^TAG_W); the new tag value identifies that request.
- R9: A response whose valid is high, whose thread field names the thread and whose tag equals that thread's tag is accepted only in WaitResponse and when no squash from R3 to R5 applies; it moves the thread to Blocked if stalled, else to AccessComplete (code 5). A fetch slot pulse then turns AccessComplete into Running (stall wins). `resp_ready_o` is constantly high.
- R10: Every valid response that no thread accepts increments the dropped-response count by one, wrapping at 2^CNT_W.
- R11: The stage-active flag is high when some thread whose active bit is set has a next status of Running, Squashing or AccessComplete; the notify output pulses in the cycle the flag changes value.
- R12: The error flag goes high for one cycle after any unblock pulse that hits a stall flag that is clear, or arrives together with a block pulse of the same stage and thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_active_i | input | NT | Threads that count toward the stage-active flag |
| ctx_switch_i | input | 1 | Global context-switch level, stalls all threads |
| stage_block_i | input | NT*4 | Block pulses, bit thread*4+stage |
| stage_unblock_i | input | NT*4 | Unblock pulses, bit thread*4+stage |
| commit_squash_i | input | NT | Commit squash request per thread |
| commit_target_i | input | NT*PC_W | Commit redirect address per thread |
| rob_squashing_i | input | NT | Reorder buffer still flushing, per thread |
| decode_squash_i | input | NT | Decode squash request per thread |
| decode_target_i | input | NT*PC_W | Decode redirect address per thread |
| fetch_req_i | input | NT | Fetch launches a cache request for the thread |
| fetch_slot_i | input | NT | Fetch slot granted to the thread |
| resp_valid_i | input | 1 | Cache response valid |
| resp_ready_o | output | 1 | Cache response ready, always high |
| resp_tid_i | input | TID_W | Thread of the response |
| resp_tag_i | input | TAG_W | Tag carried by the response |
| thread_state_o | output | NT*3 | Status code per thread |
| pc_o | output | NT*PC_W | Fetch PC per thread |
| next_pc_o | output | NT*PC_W | Next PC per thread |
| req_tag_o | output | NT*TAG_W | Tag of the outstanding request per thread |
| commit_flush_o | output | NT | Pulse: commit squash taken |
| decode_flush_o | output | NT | Pulse: decode squash taken |
| stage_active_o | output | 1 | Stage has work |
| activity_notify_o | output | 1 | Pulse on every change of stage_active_o |
| dropped_resp_o | output | CNT_W | Count of discarded responses |
| protocol_err_o | output | 1 | Pulse: unblock misuse |

## Verification
The embedded properties watch, on every cycle, that a commit squash always lands in Squashing at its own target, that a flushing reorder buffer holds a thread in Squashing, that a decode squash on an already squashing thread leaves the PC and the flush pulse alone, that a waiting thread never drops into Blocked, that block and unblock pulses reach their flags, that the drop count steps by one per discarded response, and that each notify pulse coincides with a change of the active flag. The full priority ladder, in particular how a matching response races against a squash or a stall, how a stale tag is rejected after a newer request, and how the context switch freezes all threads at once, only shows up in the bench scenarios where the reference model is compared against every output each cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int NUM_STAGES = 4;
  localparam int INST_BYTES = 4;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_BLOCK   = 3'd3,
    ST_WAIT    = 3'd4,
    ST_DONE    = 3'd5,
    ST_TRAP    = 3'd6,
    ST_QUIESCE = 3'd7
  } fstate_e;

  function automatic logic keeps_stage_busy(fstate_e s);
    return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_DONE);
  endfunction

endpackage

// File: rtl/fts_stall_flags.sv
module fts_stall_flags #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] blk,
  input  logic [NS-1:0] unblk,
  input  logic          ctx,
  output logic          stalled_d,
  output logic          misuse
);

  logic [NS-1:0] flags_q;
  logic [NS-1:0] flags_d;

  // a block pulse wins over a simultaneous unblock of the same stage
  assign flags_d   = blk | (flags_q & ~unblk);
  assign stalled_d = ctx | (|flags_d);
  assign misuse    = |(unblk & (~flags_q | blk));

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_block_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|blk) |=> ((flags_q & $past(blk)) == $past(blk)));

  assert_unblock_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(unblk & ~blk)) |=> ((flags_q & $past(unblk & ~blk)) == '0));

endmodule

// File: rtl/fts_thread_ctrl.sv
module fts_thread_ctrl
  import fts_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          TAG_W    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stalled,
  input  logic             cmt_sq,
  input  logic [PC_W-1:0]  cmt_tgt,
  input  logic             rob_sq,
  input  logic             dec_sq,
  input  logic [PC_W-1:0]  dec_tgt,
  input  logic             fetch_req,
  input  logic             fetch_slot,
  input  logic             resp_valid,
  input  logic [TAG_W-1:0] resp_tag,
  output fstate_e          state_q,
  output fstate_e          state_d,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  npc_q,
  output logic [TAG_W-1:0] tag_q,
  output logic             resp_take,
  output logic             cmt_pulse_q,
  output logic             dec_pulse_q
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic            redirect;
  logic [PC_W-1:0] new_pc;
  logic            dec_fire;
  logic            tag_bump;

  // fixed priority ladder, first match wins
  always_comb begin
    state_d   = state_q;
    redirect  = 1'b0;
    new_pc    = cmt_tgt;
    dec_fire  = 1'b0;
    resp_take = 1'b0;
    tag_bump  = 1'b0;
    if (cmt_sq) begin
      state_d  = ST_SQUASH;
      redirect = 1'b1;
    end else if (rob_sq) begin
      state_d = ST_SQUASH;
    end else if (dec_sq && state_q != ST_SQUASH) begin
      state_d  = ST_SQUASH;
      redirect = 1'b1;
      new_pc   = dec_tgt;
      dec_fire = 1'b1;
    end else if (resp_valid && state_q == ST_WAIT && resp_tag == tag_q) begin
      resp_take = 1'b1;
      state_d   = stalled ? ST_BLOCK : ST_DONE;
    end else if (stalled && state_q != ST_WAIT) begin
      state_d = ST_BLOCK;
    end else if (state_q == ST_BLOCK || state_q == ST_SQUASH) begin
      state_d = ST_RUN;
    end else if (fetch_slot && state_q == ST_DONE) begin
      state_d = ST_RUN;
    end else if (fetch_req && state_q == ST_RUN) begin
      state_d  = ST_WAIT;
      tag_bump = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      pc_q        <= RESET_PC;
      npc_q       <= RESET_PC + STEP;
      tag_q       <= '0;
      cmt_pulse_q <= 1'b0;
      dec_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      cmt_pulse_q <= cmt_sq;
      dec_pulse_q <= dec_fire;
      if (redirect) begin
        pc_q  <= new_pc;
        npc_q <= new_pc + STEP;
      end
      if (tag_bump) tag_q <= tag_q + 1'b1;
    end
  end

  assert_commit_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_sq |=> (state_q == ST_SQUASH && pc_q == $past(cmt_tgt) && cmt_pulse_q));

  assert_rob_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_sq && !cmt_sq) |=> (state_q == ST_SQUASH));

  assert_decode_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sq && !cmt_sq && !rob_sq && state_q == ST_SQUASH) |=> (!dec_pulse_q && $stable(pc_q)));

  assert_wait_not_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !cmt_sq && !rob_sq && !dec_sq && !resp_valid) |=> (state_q == ST_WAIT));

  assert_tag_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_q != $past(tag_q)) |-> (state_q == ST_WAIT));

  assert_take_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_take |=> (state_q == ST_BLOCK || state_q == ST_DONE));

endmodule

// File: rtl/fts_drop_count.sv
module fts_drop_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resp_valid,
  input  logic             any_take,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (resp_valid && !any_take) cnt_q <= cnt_q + 1'b1;
  end

  assert_drop_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !any_take) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_drop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && !any_take) |=> $stable(cnt_q));

endmodule

// File: rtl/fetch_thread_status.sv
module fetch_thread_status
  import fts_pkg::*;
#(
  parameter int              NT       = 2,
  parameter int              PC_W     = 32,
  parameter int              TAG_W    = 4,
  parameter int              CNT_W    = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             NS       = NUM_STAGES,
  localparam int             TID_W    = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NT-1:0]       thread_active_i,
  input  logic                ctx_switch_i,
  input  logic [NT*NS-1:0]    stage_block_i,
  input  logic [NT*NS-1:0]    stage_unblock_i,
  input  logic [NT-1:0]       commit_squash_i,
  input  logic [NT*PC_W-1:0]  commit_target_i,
  input  logic [NT-1:0]       rob_squashing_i,
  input  logic [NT-1:0]       decode_squash_i,
  input  logic [NT*PC_W-1:0]  decode_target_i,
  input  logic [NT-1:0]       fetch_req_i,
  input  logic [NT-1:0]       fetch_slot_i,
  input  logic                resp_valid_i,
  output logic                resp_ready_o,
  input  logic [TID_W-1:0]    resp_tid_i,
  input  logic [TAG_W-1:0]    resp_tag_i,
  output logic [NT*3-1:0]     thread_state_o,
  output logic [NT*PC_W-1:0]  pc_o,
  output logic [NT*PC_W-1:0]  next_pc_o,
  output logic [NT*TAG_W-1:0] req_tag_o,
  output logic [NT-1:0]       commit_flush_o,
  output logic [NT-1:0]       decode_flush_o,
  output logic                stage_active_o,
  output logic                activity_notify_o,
  output logic [CNT_W-1:0]    dropped_resp_o,
  output logic                protocol_err_o
);

  fstate_e        st_q [NT];
  fstate_e        st_d [NT];
  logic [NT-1:0]  stalled;
  logic [NT-1:0]  misuse;
  logic [NT-1:0]  take;
  logic           busy_d;

  // responses are never back-pressured
  assign resp_ready_o = 1'b1;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic resp_mine;
    assign resp_mine = resp_valid_i && (resp_tid_i == TID_W'(t));

    fts_stall_flags #(.NS(NS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk       (stage_block_i[t*NS +: NS]),
      .unblk     (stage_unblock_i[t*NS +: NS]),
      .ctx       (ctx_switch_i),
      .stalled_d (stalled[t]),
      .misuse    (misuse[t])
    );

    fts_thread_ctrl #(.PC_W(PC_W), .TAG_W(TAG_W), .RESET_PC(RESET_PC)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .stalled     (stalled[t]),
      .cmt_sq      (commit_squash_i[t]),
      .cmt_tgt     (commit_target_i[t*PC_W +: PC_W]),
      .rob_sq      (rob_squashing_i[t]),
      .dec_sq      (decode_squash_i[t]),
      .dec_tgt     (decode_target_i[t*PC_W +: PC_W]),
      .fetch_req   (fetch_req_i[t]),
      .fetch_slot  (fetch_slot_i[t]),
      .resp_valid  (resp_mine),
      .resp_tag    (resp_tag_i),
      .state_q     (st_q[t]),
      .state_d     (st_d[t]),
      .pc_q        (pc_o[t*PC_W +: PC_W]),
      .npc_q       (next_pc_o[t*PC_W +: PC_W]),
      .tag_q       (req_tag_o[t*TAG_W +: TAG_W]),
      .resp_take   (take[t]),
      .cmt_pulse_q (commit_flush_o[t]),
      .dec_pulse_q (decode_flush_o[t])
    );

    assign thread_state_o[t*3 +: 3] = st_q[t];
  end

  fts_drop_count #(.CNT_W(CNT_W)) u_drop (
    .clk        (clk),
    .rst_n      (rst_n),
    .resp_valid (resp_valid_i),
    .any_take   (|take),
    .cnt_q      (dropped_resp_o)
  );

  always_comb begin
    busy_d = 1'b0;
    for (int t = 0; t < NT; t++) begin
      if (thread_active_i[t] && keeps_stage_busy(st_d[t])) busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_active_o    <= 1'b0;
      activity_notify_o <= 1'b0;
      protocol_err_o    <= 1'b0;
    end else begin
      stage_active_o    <= busy_d;
      activity_notify_o <= busy_d ^ stage_active_o;
      protocol_err_o    <= |misuse;
    end
  end

  assert_notify_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    activity_notify_o |-> (stage_active_o != $past(stage_active_o)));

  assert_one_taker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

endmodule

// File: tb/tb_fetch_thread_status.sv
`timescale 1ns/1ps
module tb_fetch_thread_status;

  localparam int NT = 2;
  localparam int PC_W = 32;
  localparam int TAG_W = 4;
  localparam int CNT_W = 8;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  thr_act = 2'b11;
  logic        ctx = 1'b0;
  logic [7:0]  blk = '0, ublk = '0;
  logic [1:0]  csq = '0, rsq = '0, dsq = '0, req = '0, slot = '0;
  logic [63:0] ctgt = '0, dtgt = '0;
  logic        rv = 1'b0;
  logic        rtid = 1'b0;
  logic [3:0]  rtag = '0;

  logic        ready;
  logic [5:0]  st_o;
  logic [63:0] pc_o, npc_o;
  logic [7:0]  tag_o;
  logic [1:0]  cfl_o, dfl_o;
  logic        act_o, not_o, err_o;
  logic [7:0]  cnt_o;

  fetch_thread_status #(.NT(NT), .PC_W(PC_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .RESET_PC(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .thread_active_i(thr_act), .ctx_switch_i(ctx),
    .stage_block_i(blk), .stage_unblock_i(ublk),
    .commit_squash_i(csq), .commit_target_i(ctgt), .rob_squashing_i(rsq),
    .decode_squash_i(dsq), .decode_target_i(dtgt),
    .fetch_req_i(req), .fetch_slot_i(slot),
    .resp_valid_i(rv), .resp_ready_o(ready), .resp_tid_i(rtid), .resp_tag_i(rtag),
    .thread_state_o(st_o), .pc_o(pc_o), .next_pc_o(npc_o), .req_tag_o(tag_o),
    .commit_flush_o(cfl_o), .decode_flush_o(dfl_o),
    .stage_active_o(act_o), .activity_notify_o(not_o),
    .dropped_resp_o(cnt_o), .protocol_err_o(err_o)
  );

  // reference model state
  int          mst [2];
  logic [31:0] mpc [2], mnpc [2];
  logic [3:0]  mtag [2];
  bit          mflag [2][4];
  bit          mcf [2], mdf [2];
  bit          mact, mnot, merr;
  logic [7:0]  mcnt;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string req_name, int t, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s thread=%0d actual=%0h expected=%0h", req_name, t, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 2; t++) begin
      mst[t] = 0; mpc[t] = RPC; mnpc[t] = RPC + 4; mtag[t] = 0;
      mcf[t] = 0; mdf[t] = 0;
      for (int s = 0; s < 4; s++) mflag[t][s] = 0;
    end
    mact = 0; mnot = 0; merr = 0; mcnt = 0;
  endtask

  task automatic model_step();
    bit any_take;
    bit errv;
    bit nact;
    any_take = 0; errv = 0; nact = 0;
    for (int t = 0; t < 2; t++) begin
      bit stl;
      stl = ctx;
      for (int s = 0; s < 4; s++) begin
        if (ublk[t*4+s] && (!mflag[t][s] || blk[t*4+s])) errv = 1;
        mflag[t][s] = blk[t*4+s] || (mflag[t][s] && !ublk[t*4+s]);
        if (mflag[t][s]) stl = 1;
      end
      mcf[t] = csq[t];
      mdf[t] = 0;
      if (csq[t]) begin
        mst[t] = 2; mpc[t] = ctgt[t*32 +: 32]; mnpc[t] = mpc[t] + 4;
      end else if (rsq[t]) begin
        mst[t] = 2;
      end else if (dsq[t] && mst[t] != 2) begin
        mst[t] = 2; mpc[t] = dtgt[t*32 +: 32]; mnpc[t] = mpc[t] + 4; mdf[t] = 1;
      end else if (rv && int'(rtid) == t && mst[t] == 4 && rtag == mtag[t]) begin
        any_take = 1;
        mst[t] = stl ? 3 : 5;
      end else if (stl && mst[t] != 4) begin
        mst[t] = 3;
      end else if (mst[t] == 3 || mst[t] == 2) begin
        mst[t] = 0;
      end else if (slot[t] && mst[t] == 5) begin
        mst[t] = 0;
      end else if (req[t] && mst[t] == 0) begin
        mst[t] = 4; mtag[t] = mtag[t] + 1;
      end
      if (thr_act[t] && (mst[t] == 0 || mst[t] == 2 || mst[t] == 5)) nact = 1;
    end
    if (rv && !any_take) mcnt = mcnt + 1;
    mnot = (nact != mact);
    mact = nact;
    merr = errv;
  endtask

  task automatic compare();
    for (int t = 0; t < 2; t++) begin
      chk("R6 state", t, 64'(st_o[t*3 +: 3]), 64'(mst[t]));
      chk("R3 pc", t, 64'(pc_o[t*32 +: 32]), 64'(mpc[t]));
      chk("R5 next_pc", t, 64'(npc_o[t*32 +: 32]), 64'(mnpc[t]));
      chk("R8 tag", t, 64'(tag_o[t*4 +: 4]), 64'(mtag[t]));
      chk("R3 commit_flush", t, 64'(cfl_o[t]), 64'(mcf[t]));
      chk("R5 decode_flush", t, 64'(dfl_o[t]), 64'(mdf[t]));
    end
    chk("R11 active", 0, 64'(act_o), 64'(mact));
    chk("R11 notify", 0, 64'(not_o), 64'(mnot));
    chk("R10 dropped", 0, 64'(cnt_o), 64'(mcnt));
    chk("R12 error", 0, 64'(err_o), 64'(merr));
    chk("R9 ready", 0, 64'(ready), 64'd1);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    blk = '0; ublk = '0; csq = '0; dsq = '0; req = '0; slot = '0; rv = 1'b0;
  endtask

  bit done = 0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int t = 0; t < 2; t++) begin
      chk("R1 state", t, 64'(st_o[t*3 +: 3]), 64'd0);
      chk("R1 pc", t, 64'(pc_o[t*32 +: 32]), 64'(RPC));
      chk("R1 next_pc", t, 64'(npc_o[t*32 +: 32]), 64'(RPC + 4));
      chk("R1 tag", t, 64'(tag_o[t*4 +: 4]), 64'd0);
    end
    chk("R1 active", 0, 64'(act_o), 64'd0);
    chk("R1 dropped", 0, 64'(cnt_o), 64'd0);
    chk("R1 error", 0, 64'(err_o), 64'd0);
    rst_n = 1'b1;
    cyc(); cyc();

    // R8 then R9: request, matching response, fetch slot
    req[0] = 1; cyc();
    rv = 1; rtid = 0; rtag = mtag[0]; cyc();
    slot[0] = 1; cyc();

    // R10: stale tag after a newer request is dropped
    req[0] = 1; cyc();
    rv = 1; rtid = 0; rtag = mtag[0] - 1; cyc();
    rv = 1; rtid = 1; rtag = mtag[1]; cyc();     // thread 1 not waiting

    // R2, R6, R9: stall while waiting, response lands in Blocked, R7 release
    blk[1] = 1; cyc();
    cyc();
    rv = 1; rtid = 0; rtag = mtag[0]; cyc();
    ublk[1] = 1; cyc();
    cyc();

    // R3: commit squash cancels the outstanding request
    req[0] = 1; cyc();
    csq[0] = 1; ctgt[31:0] = 32'h0000_2000; cyc();
    rv = 1; rtid = 0; rtag = mtag[0]; cyc();
    cyc();

    // R4: flushing reorder buffer holds Squashing; R5 decode squash ignored meanwhile
    rsq[0] = 1; cyc(); cyc();
    dsq[0] = 1; dtgt[31:0] = 32'h0000_3000; cyc();
    rsq[0] = 0;
    dsq[0] = 1; dtgt[31:0] = 32'h0000_3300; cyc();
    cyc();

    // R5: decode squash on a running thread
    dsq[1] = 1; dtgt[63:32] = 32'h0000_4000; cyc();
    cyc();
    // R3 over R5: both in the same cycle
    csq[1] = 1; ctgt[63:32] = 32'h0000_5000; dsq[1] = 1; dtgt[63:32] = 32'h0000_6000; cyc();
    cyc();

    // R2, R6: context switch blocks every thread, R7 release
    ctx = 1; cyc(); cyc();
    ctx = 0; cyc(); cyc();

    // R11: no active threads, then back
    thr_act = 2'b00; cyc(); cyc();
    thr_act = 2'b11; cyc(); cyc();

    // R12: unblock of a clear flag, then unblock together with block
    ublk[5] = 1; cyc();
    blk[6] = 1; ublk[6] = 1; cyc();
    ublk[6] = 1; cyc();
    cyc();

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      thr_act = ($urandom_range(0, 30) == 0) ? 2'($urandom) : thr_act | 2'($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 60) == 0) ctx = ~ctx;
      for (int b = 0; b < 8; b++) begin
        blk[b]  = ($urandom_range(0, 40) == 0);
        ublk[b] = ($urandom_range(0, 8) == 0) && (mflag[b/4][b%4] || $urandom_range(0, 20) == 0);
      end
      for (int t = 0; t < 2; t++) begin
        csq[t]  = ($urandom_range(0, 40) == 0);
        rsq[t]  = ($urandom_range(0, 25) == 0);
        dsq[t]  = ($urandom_range(0, 20) == 0);
        req[t]  = ($urandom_range(0, 2) == 0);
        slot[t] = ($urandom_range(0, 2) == 0);
      end
      ctgt = {$urandom, $urandom};
      dtgt = {$urandom, $urandom};
      rv   = ($urandom_range(0, 2) == 0);
      rtid = 1'($urandom);
      rtag = ($urandom_range(0, 3) == 0) ? 4'($urandom) : mtag[rtid];
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule